// File: doc/BRIEF.md
# Privilege-Filtered Flags Loader

This block holds a processor's 16-bit status word and controls what a flags-load operation is allowed to change. Each load offers a new word, together with the current operating mode (real or protected) and the 2-bit current privilege level. The block then decides bit by bit whether the offered value or the old value is stored. Real-mode loads clear the top nibble. Protected-mode loads made at a nonzero privilege level cannot change the I/O privilege field. Protected-mode loads made at a privilege level numerically above the stored I/O privilege field also cannot change the interrupt-enable bit.

After a load, the block reports two follow-up events to the surrounding core, each as a single-clock pulse. The first is a single-step trap request, raised when the stored trap bit is set. The second is an interrupt-accept request, raised when the stored interrupt-enable bit is set and an interrupt was pending at the time of the load. The core sequences these events. Flag arithmetic and interrupt servicing are outside this block.

Top module: `flags_guard_loader`

## Requirements
- R1: While reset is active, and in the first cycle after it, the stored word reads 0x0002 and both request outputs are low.
- R2: In a cycle where the write strobe is low, the stored word keeps its value and both request outputs are low in the following cycle.
- R3: A protected-mode load at privilege level 0 stores the offered word unchanged, apart from bit 1.
- R4: A protected-mode load at a nonzero privilege level leaves bits 13:12 (the I/O privilege field) at their old value. All other bits except bit 9 and bit 1 take the offered value.
- R5: A protected-mode load whose privilege level is numerically greater than the I/O privilege field leaves bit 9 (interrupt enable) at its old value. Otherwise bit 9 takes the offered value.
- R6: The I/O privilege field used in the R5 comparison is the one stored before the load, not the one offered.
- R7: A real-mode load stores zero in bits 15:12, whatever the privilege level, and stores the offered value in bits 11:0.
- R8: Bit 1 of the stored word always reads one.
- R9: In the cycle after a load that leaves bit 8 (trap) set, `step_trap` is high for exactly one cycle.
- R10: In the cycle after a load that leaves bit 9 set while `irq_pending` was high, `irq_take` is high for exactly one cycle.
- R11: One load can raise both `step_trap` and `irq_take` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load strobe |
| wr_data | input | 16 | Offered flags word |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| cur_priv | input | 2 | Current privilege level, 0 = most privileged |
| irq_pending | input | 1 | An interrupt is waiting |
| flags_q | output | 16 | Stored flags word |
| step_trap | output | 1 | Single-step trap request pulse |
| irq_take | output | 1 | Interrupt-accept request pulse |

## Verification
The trap request and the interrupt-accept request can occur in the same cycle. This happens when one load leaves both the trap bit and the interrupt-enable bit set while an interrupt is pending. The bench forces this case on purpose at privilege level 0. It also reaches the case under random loads where the interrupt-enable bit is held back by the privilege filter, so an accept can follow from the old enable value. A behavioural model predicts the stored word and both pulses every cycle, and the bench compares all three outputs against it in the same cycle.

// File: rtl/flg_pkg.sv
package flg_pkg;
  localparam int FLG_W     = 16;
  localparam int PRIV_W    = 2;
  localparam int IOPL_LO   = 12;
  localparam int IOPL_W    = 2;
  localparam int IE_POS    = 9;
  localparam int TF_POS    = 8;
  localparam int RSV_POS   = 1;
  localparam int RM_CLR_LO = 12;
  typedef logic [FLG_W-1:0] flags_t;
  localparam flags_t FLAGS_RST = flags_t'(1) << RSV_POS;
endpackage

// File: rtl/flg_keep_mask.sv
module flg_keep_mask
  import flg_pkg::*;
#(
  parameter int W       = FLG_W,
  parameter int PW      = PRIV_W,
  parameter int FLD_LO  = IOPL_LO,
  parameter int FLD_W   = IOPL_W,
  parameter int IE_BIT  = IE_POS,
  parameter int CLR_LO  = RM_CLR_LO
) (
  input  logic             prot_mode,
  input  logic [PW-1:0]    cur_priv,
  input  logic [FLD_W-1:0] old_field,
  output logic [W-1:0]     keep_mask,
  output logic [W-1:0]     clr_mask
);
  logic user_lvl;
  logic ie_locked;

  always_comb begin
    user_lvl  = prot_mode && (cur_priv != '0);
    ie_locked = prot_mode && (PW'(cur_priv) > PW'(old_field));
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b >= FLD_LO && b < FLD_LO + FLD_W) begin : g_fld
      assign keep_mask[b] = user_lvl;
    end else if (b == IE_BIT) begin : g_ie
      assign keep_mask[b] = ie_locked;
    end else begin : g_free
      assign keep_mask[b] = 1'b0;
    end
    if (b >= CLR_LO) begin : g_hi
      assign clr_mask[b] = ~prot_mode;
    end else begin : g_lo
      assign clr_mask[b] = 1'b0;
    end
  end
endmodule

// File: rtl/flg_merge.sv
module flg_merge
  import flg_pkg::*;
#(
  parameter int W      = FLG_W,
  parameter int ONE_AT = RSV_POS
) (
  input  logic [W-1:0] old_word,
  input  logic [W-1:0] req_word,
  input  logic [W-1:0] keep_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] new_word
);
  localparam logic [W-1:0] ONE_MASK = {{(W-1){1'b0}}, 1'b1} << ONE_AT;

  always_comb begin
    new_word = (req_word & ~keep_mask & ~clr_mask) | (old_word & keep_mask);
    new_word = new_word | ONE_MASK;
  end
endmodule

// File: rtl/flg_event_gen.sv
module flg_event_gen
  import flg_pkg::*;
#(
  parameter int W      = FLG_W,
  parameter int TF_BIT = TF_POS,
  parameter int IE_BIT = IE_POS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] loaded_word,
  input  logic         irq_pending,
  output logic         step_trap,
  output logic         irq_take
);
  logic trap_d, take_d;

  always_comb begin
    trap_d = load && loaded_word[TF_BIT];
    take_d = load && loaded_word[IE_BIT] && irq_pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_trap <= 1'b0;
      irq_take  <= 1'b0;
    end else begin
      step_trap <= trap_d;
      irq_take  <= take_d;
    end
  end
endmodule

// File: rtl/flags_guard_loader.sv
module flags_guard_loader
  import flg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLG_W-1:0]  wr_data,
  input  logic              prot_mode,
  input  logic [PRIV_W-1:0] cur_priv,
  input  logic              irq_pending,
  output logic [FLG_W-1:0]  flags_q,
  output logic              step_trap,
  output logic              irq_take
);
  flags_t keep_mask, clr_mask, merged, flags_d;

  flg_keep_mask u_mask (
    .prot_mode (prot_mode),
    .cur_priv  (cur_priv),
    .old_field (flags_q[IOPL_LO +: IOPL_W]),
    .keep_mask (keep_mask),
    .clr_mask  (clr_mask)
  );

  flg_merge u_merge (
    .old_word  (flags_q),
    .req_word  (wr_data),
    .keep_mask (keep_mask),
    .clr_mask  (clr_mask),
    .new_word  (merged)
  );

  always_comb begin
    flags_d = flags_q;
    if (wr_en) flags_d = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= FLAGS_RST;
    else        flags_q <= flags_d;
  end

  flg_event_gen u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (wr_en),
    .loaded_word (merged),
    .irq_pending (irq_pending),
    .step_trap   (step_trap),
    .irq_take    (irq_take)
  );
endmodule

// File: rtl/flags_guard_loader_chk.sv
module flags_guard_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        prot_mode,
  input logic [1:0]  cur_priv,
  input logic        irq_pending,
  input logic [15:0] flags_q,
  input logic        step_trap,
  input logic        irq_take
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(flags_q) && !step_trap && !irq_take));

  assert_full_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && prot_mode && cur_priv == 2'd0) |=> flags_q == ($past(wr_data) | 16'h0002));

  assert_field_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && prot_mode && cur_priv != 2'd0) |=> flags_q[13:12] == $past(flags_q[13:12]));

  assert_ie_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && prot_mode && cur_priv > flags_q[13:12]) |=> flags_q[9] == $past(flags_q[9]));

  assert_real_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !prot_mode) |=> (flags_q[15:12] == 4'h0 && flags_q[11:2] == $past(wr_data[11:2])));

  assert_trap_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_trap |-> ($past(wr_en) && flags_q[8]));

  assert_trap_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_trap |=> !step_trap || $past(wr_en));

  assert_take_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> ($past(wr_en) && $past(irq_pending) && flags_q[9]));

  always @(negedge clk) begin
    if (rst_n) begin
      assert_reserved_R8: assert (flags_q[1] == 1'b1);
    end
  end
endmodule

bind flags_guard_loader flags_guard_loader_chk u_chk (.*);

// File: tb/flags_guard_loader_test.sv
module flags_guard_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        prot_mode = 1'b0;
  logic [1:0]  cur_priv = '0;
  logic        irq_pending = 1'b0;
  logic [15:0] flags_q;
  logic        step_trap, irq_take;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  int unsigned m_flags = 32'h2;
  bit m_trap = 0, m_take = 0;

  always #2 clk = ~clk;

  flags_guard_loader uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .prot_mode(prot_mode), .cur_priv(cur_priv), .irq_pending(irq_pending),
    .flags_q(flags_q), .step_trap(step_trap), .irq_take(irq_take)
  );

  // behavioural reference, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = 2; m_trap = 0; m_take = 0;
    end else if (wr_en) begin
      int unsigned nv;
      int unsigned old_fld;
      nv = wr_data;
      old_fld = (m_flags >> 12) & 3;
      if (!prot_mode) nv = nv & 32'h0FFF;
      else if (cur_priv != 0) begin
        nv = (nv & ~32'h3000) | (m_flags & 32'h3000);
        if (int'(cur_priv) > int'(old_fld)) nv = (nv & ~32'h0200) | (m_flags & 32'h0200);
      end
      nv = nv | 2;
      m_flags = nv;
      m_trap = ((nv >> 8) & 1) == 1;
      m_take = (((nv >> 9) & 1) == 1) && irq_pending;
    end else begin
      m_trap = 0; m_take = 0;
    end
  end

  task automatic check(input string req, input int unsigned act, input int unsigned exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(cur_req, flags_q, m_flags, "flags");
    check(cur_req, step_trap, m_trap, "step_trap");
    check(cur_req, irq_take, m_take, "irq_take");
  end

  task automatic load(input logic [15:0] d, input logic pm, input logic [1:0] pl,
                      input logic irq, input string req);
    @(negedge clk);
    #1;
    cur_req = req;
    wr_en = 1; wr_data = d; prot_mode = pm; cur_priv = pl; irq_pending = irq;
    @(negedge clk);
    #1;
    wr_en = 0; wr_data = ~d; irq_pending = ~irq;
  endtask

  task automatic expect_word(input string req, input logic [15:0] exp);
    @(negedge clk);
    #1;
    check(req, flags_q, exp, "directed");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", flags_q, 16'h0002, "reset word");
    #1 rst_n = 1;
    @(negedge clk);
    check("R1", {step_trap, irq_take}, 0, "pulses after reset");
    // both pulses from one privileged load
    load(16'hF3FF, 1, 0, 1, "R11");
    expect_word("R3", 16'hF3FF);
    cur_req = "R2";
    repeat (3) @(negedge clk);
    load(16'h0000, 1, 3, 0, "R4");
    expect_word("R4", 16'h3002);
    load(16'h1200, 1, 0, 0, "R3");
    expect_word("R3", 16'h1202);
    // offered field 2 would permit, stored field 1 forbids
    load(16'h2000, 1, 2, 1, "R6");
    expect_word("R5", 16'h1202);
    load(16'h0100, 1, 1, 1, "R9");
    expect_word("R9", 16'h1102);
    load(16'hFFFD, 0, 3, 1, "R7");
    expect_word("R8", 16'h0FFF);
    load(16'h0000, 1, 0, 0, "R8");
    expect_word("R8", 16'h0002);
    for (int i = 0; i < 300; i++) begin
      load(16'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), "R10");
      if ($urandom_range(0, 2) == 0) begin
        cur_req = "R2";
        @(negedge clk);
      end
    end
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule